// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block is the bypass control for a five-stage in-order integer pipeline. For each of the two source operands of the instruction now in the execute stage, it decides where the ALU input comes from. The input can be the value read from the register file. It can also be a result held in the nearer pipeline register, between execute and memory. Or it can be a result held in the farther one, between memory and write-back.

The block compares each producer's destination register number against each operand's source register number. That gives four equality compares in all. A producer counts only when its register-write flag is set and its destination is not register zero. When both producers match the same operand, the nearer one wins, because it holds the more recent value. The decision logic is purely combinational. A thin output register lets the selects be observed one clock after the register numbers are presented.

Top module: `fwd_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, both selects become 2'b00, and they stay 2'b00 until the first edge with `rst_n` high.
- R2: When the near producer's write flag is set, its destination is nonzero and equals an operand's source, that operand's select becomes 2'b10.
- R3: When only the far producer qualifies for an operand (write flag set, nonzero destination equal to the source), that operand's select becomes 2'b01.
- R4: When both producers qualify for the same operand, its select is 2'b10 (the near producer takes priority).
- R5: A destination of register 0 is never forwarded, so a source of 0 always gives select 2'b00.
- R6: A producer whose write flag is clear is ignored, even when its destination matches.
- R7: When neither producer qualifies, the select is 2'b00 (register file).
- R8: Operand A and operand B are decided independently, each against both producers.
- R9: Each select takes its new value at the rising edge after its inputs are presented, and it holds its previous value before that edge.
- R10: A select never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_a | input | REG_AW | Source register number of operand A in the execute stage |
| src_b | input | REG_AW | Source register number of operand B in the execute stage |
| near_dst | input | REG_AW | Destination register held in the execute/memory register |
| near_wr | input | 1 | Register-write flag of the execute/memory producer |
| far_dst | input | REG_AW | Destination register held in the memory/write-back register |
| far_wr | input | 1 | Register-write flag of the memory/write-back producer |
| sel_a | output | 2 | Operand A source: 00 register file, 10 near, 01 far |
| sel_b | output | 2 | Operand B source: 00 register file, 10 near, 01 far |

## Verification
The block keeps no state apart from the output register. A wrong compare or a wrong priority decision therefore shows up as a wrong select code one clock after the offending register numbers are presented, and it disappears as soon as the inputs change. Because of this, the bench sweeps every combination of a small register subset, enables and zero destinations, and checks each select after every edge. It also checks that a select does not move before that edge.

// File: rtl/fwd_pkg.sv
// Shared select encoding for the operand forwarding unit.
// Assumes a two-bit select feeding a three-input ALU operand mux.
package fwd_pkg;
    typedef enum logic [1:0] {
        SEL_REGFILE = 2'b00,
        SEL_FAR     = 2'b01,
        SEL_NEAR    = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/fwd_producer_match.sv
// Compares one producer's destination against every operand source.
// Assumes register 0 is hard-wired to zero and must never be forwarded.
module fwd_producer_match #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [REG_AW-1:0]              dst,
    input  logic                           wr_en,
    input  logic [NUM_SRC-1:0][REG_AW-1:0] srcs,
    output logic [NUM_SRC-1:0]             hit
);
    logic live;

    // Producer qualifies only when writing a nonzero register.
    assign live = wr_en && (dst != '0);

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
            // One equality comparator per source/destination pair.
            assign hit[i] = live && (srcs[i] == dst);
        end
    endgenerate
endmodule

// File: rtl/fwd_select.sv
// Turns the two producer hits for one operand into a mux select.
// Assumes the near producer holds the younger result and wins ties.
module fwd_select
    import fwd_pkg::*;
(
    input  logic     near_hit,
    input  logic     far_hit,
    output fwd_sel_e sel
);
    // Priority pick: near, then far, then register file.
    always_comb begin
        if (near_hit)     sel = SEL_NEAR;
        else if (far_hit) sel = SEL_FAR;
        else              sel = SEL_REGFILE;
    end
endmodule

// File: rtl/fwd_unit.sv
// Operand forwarding unit: decides ALU operand sources from register
// numbers, with selects registered once for cycle-level observation.
// Assumes synchronous active-low reset and two ALU operands.
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] src_a,
    input  logic [REG_AW-1:0] src_b,
    input  logic [REG_AW-1:0] near_dst,
    input  logic              near_wr,
    input  logic [REG_AW-1:0] far_dst,
    input  logic              far_wr,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b
);
    localparam int NUM_SRC = 2;

    logic [NUM_SRC-1:0][REG_AW-1:0] srcs;
    logic [NUM_SRC-1:0]             near_hit;
    logic [NUM_SRC-1:0]             far_hit;
    fwd_sel_e                       sel_next [NUM_SRC];
    fwd_sel_e                       sel_q    [NUM_SRC];

    assign srcs[0] = src_a;
    assign srcs[1] = src_b;

    fwd_producer_match #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_near (
        .dst   (near_dst),
        .wr_en (near_wr),
        .srcs  (srcs),
        .hit   (near_hit)
    );

    fwd_producer_match #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_far (
        .dst   (far_dst),
        .wr_en (far_wr),
        .srcs  (srcs),
        .hit   (far_hit)
    );

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_op
            fwd_select u_sel (
                .near_hit (near_hit[i]),
                .far_hit  (far_hit[i]),
                .sel      (sel_next[i])
            );

            // Output register for one operand select.
            always_ff @(posedge clk) begin
                if (!rst_n) sel_q[i] <= SEL_REGFILE;
                else        sel_q[i] <= sel_next[i];
            end
        end
    endgenerate

    assign sel_a = sel_q[0];
    assign sel_b = sel_q[1];
endmodule

// File: rtl/fwd_unit_chk.sv
// Property checker for fwd_unit, attached through bind.
// Assumes the one-cycle registered select timing of the top module.
module fwd_unit_chk #(
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] src_a,
    input logic [REG_AW-1:0] src_b,
    input logic [REG_AW-1:0] near_dst,
    input logic              near_wr,
    input logic [REG_AW-1:0] far_dst,
    input logic              far_wr,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b
);
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (sel_a == 2'b00 && sel_b == 2'b00)); // R1
    AST_NEAR_A: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(near_wr && near_dst != '0 && near_dst == src_a)
        |-> sel_a == 2'b10); // R2
    AST_NEAR_B: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(near_wr && near_dst != '0 && near_dst == src_b)
        |-> sel_b == 2'b10); // R8
    AST_FAR_A: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(far_wr && far_dst != '0 && far_dst == src_a
            && !(near_wr && near_dst == src_a)) |-> sel_a == 2'b01); // R3
    AST_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(src_a == '0) |-> sel_a == 2'b00); // R5
    AST_WRITE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!near_wr && !far_wr)
        |-> (sel_a == 2'b00 && sel_b == 2'b00)); // R6
    AST_NO_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        sel_a != 2'b11 && sel_b != 2'b11); // R10
endmodule

bind fwd_unit fwd_unit_chk #(.REG_AW(REG_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
    .near_dst(near_dst), .near_wr(near_wr), .far_dst(far_dst),
    .far_wr(far_wr), .sel_a(sel_a), .sel_b(sel_b)
);

// File: tb/fwd_unit_test.sv
// Near-exhaustive sweep of fwd_unit over registers 0..3 plus high numbers.
module fwd_unit_test;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] src_a = '0, src_b = '0, near_dst = '0, far_dst = '0;
    logic          near_wr = 1'b0, far_wr = 1'b0;
    logic [1:0]    sel_a, sel_b;
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done = 0;
    logic [1:0]    prev_a = 2'b00, prev_b = 2'b00;

    always #2.5 clk = ~clk;

    fwd_unit #(.REG_AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
        .near_dst(near_dst), .near_wr(near_wr), .far_dst(far_dst),
        .far_wr(far_wr), .sel_a(sel_a), .sel_b(sel_b)
    );

    function automatic logic [1:0] want(input int s, input int nd, input bit nw,
                                        input int fd, input bit fw);
        if (nw && nd != 0 && nd == s) return 2'b10;
        if (fw && fd != 0 && fd == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic string tag(input int s, input int nd, input bit nw,
                                  input int fd, input bit fw);
        bit nq = nw && nd != 0 && nd == s;
        bit fq = fw && fd != 0 && fd == s;
        if (nq && fq) return "R4";
        if (nq) return "R2";
        if (fq) return "R3";
        if (s == 0) return "R5";
        if ((nd == s) || (fd == s)) return "R6";
        return "R7";
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp || act === 2'b11) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", act === 2'b11 ? "R10" : req, act, exp);
        end
    endtask

    task automatic apply(input int sa, input int sb, input int nd, input bit nw,
                         input int fd, input bit fw);
        logic [1:0] ea = want(sa, nd, nw, fd, fw);
        logic [1:0] eb = want(sb, nd, nw, fd, fw);
        @(negedge clk);
        src_a = AW'(sa); src_b = AW'(sb); near_dst = AW'(nd); far_dst = AW'(fd);
        near_wr = nw; far_wr = fw;
        #1;
        check("R9", sel_a, prev_a);   // no change before the edge
        @(negedge clk);
        check(tag(sa, nd, nw, fd, fw), sel_a, ea);
        check({"R8/", tag(sb, nd, nw, fd, fw)}, sel_b, eb);
        prev_a = ea; prev_b = eb;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset forces register-file selects even with matching inputs.
        src_a = 5'd3; near_dst = 5'd3; near_wr = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", sel_a, 2'b00);
        check("R1", sel_b, 2'b00);
        near_wr = 1'b0; near_dst = '0; src_a = '0;
        @(negedge clk);
        rst_n = 1'b1;

        for (int nd = 0; nd < 4; nd++)
            for (int nw = 0; nw < 2; nw++)
                for (int fd = 0; fd < 4; fd++)
                    for (int fw = 0; fw < 2; fw++)
                        for (int sa = 0; sa < 4; sa++)
                            for (int sb = 0; sb < 4; sb++)
                                apply(sa, sb, nd, nw[0], fd, fw[0]);

        // High register numbers, operands split across producers (R8).
        apply(31, 17, 31, 1'b1, 17, 1'b1);
        apply(17, 31, 31, 1'b1, 17, 1'b1);
        apply(31, 31, 31, 1'b1, 31, 1'b1);
        apply(30, 31, 31, 1'b1, 30, 1'b0);
        apply(16, 16, 0, 1'b1, 16, 1'b1);

        // R1 again: reset mid-run clears a forwarding select.
        apply(5, 6, 5, 1'b1, 6, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", sel_a, 2'b00);
        check("R1", sel_b, 2'b00);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule